// File: doc/BRIEF.md
# Flash Sector Read-Back Sequencer

This block walks a management host through reading back a span of 64 KB flash sectors. The host picks a flash device and then names a first and a last sector. The block fetches one sector into an external sector buffer through a request/complete handshake. It reports the sector as ready once the fetch and its integrity check finish, and then hands the sector out in fixed-size transactions. When the last transaction of a sector has gone out, the host must collect the sector's 8-byte checksum. Only after that does the block fetch the next sector. After the last sector's checksum, the block returns to idle.

Commands arrive on a plain control port. Each accepted command yields a one-cycle response code. Sector bytes and checksum bytes leave on a single valid/ready byte stream. The checksum itself is computed outside the block and delivered with the fetch completion. A set-sector command lets the host restart read-back at the beginning of any sector in the current span. A fetch that is already in flight is discarded when this happens.

Top module: `flash_readback_seq`

## Requirements
- R1: After reset the block is idle. A status poll returns 0xFF, `fetch_valid` and `tx_valid` are low, and `cmd_ready` is high.
- R2: A range command (op 1, `cmd_arg_a` first sector, `cmd_arg_b` last sector) is rejected with 0x82 and leaves the block idle if either sector exceeds 2047 or the first exceeds the last.
- R3: A device select (op 0) accepts 1 to 4 with 0x01 and rejects other values with 0x08. A range command sent before any accepted device select returns 0x23.
- R4: An accepted range returns 0x01 and raises `fetch_valid` with the first sector and the selected device. `fetch_valid` holds until `fetch_ready`.
- R5: A status poll (op 3) returns 0x80 while a fetch is outstanding. It returns 0x81 once a fetch completes with `fetch_ok` high. It returns 0x07 after a completion with `fetch_ok` low.
- R6: A data request (op 4) returns 0x02 and sends nothing unless the sector is ready and a poll has returned 0x81 for it. The transaction counter does not advance on a rejected request.
- R7: An accepted data request returns 0x01 and then streams exactly TXN_BYTES bytes. Transaction t, byte k is read from buffer address t*TXN_BYTES+k. `tx_last` is high on the final byte.
- R8: While `tx_valid` is high and `tx_ready` is low, the byte, its buffer address and `tx_last` hold. `cmd_ready` stays low for as long as a stream is active.
- R9: After TXNS_PER_SECTOR transactions, data requests return 0x02. A checksum request (op 5) is accepted only at this point, returning 0x01 and then streaming the fetched checksum least significant byte first, with `tx_last` on byte 8. Earlier checksum requests return 0x02.
- R10: Once the checksum has been streamed, the next sector is fetched. After the last sector's checksum the block goes idle and polls return 0xFF.
- R11: A set-sector command (op 2) with a sector inside the current span returns 0x01 and restarts read-back at transaction 0 of that sector. A sector outside the span returns 0x82. When idle it returns 0x02.
- R12: A set-sector command issued while a fetch is in flight causes that fetch's completion to be ignored. The new sector is then requested.
- R13: Op codes 6 and 7 return 0x03.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_op | input | 3 | Command operation |
| cmd_arg_a | input | SECT_W | First argument (device, first sector, or sector) |
| cmd_arg_b | input | SECT_W | Second argument (last sector) |
| rsp_valid | output | 1 | Response strobe, one cycle after acceptance |
| rsp_code | output | 8 | Response code |
| fetch_valid | output | 1 | Sector fetch request |
| fetch_ready | input | 1 | Fetch request taken |
| fetch_sector | output | SECT_W | Sector to fetch |
| fetch_dev | output | DEV_W | Flash device to fetch from |
| fetch_done | input | 1 | Fetch complete pulse |
| fetch_ok | input | 1 | Fetch integrity result, with fetch_done |
| fetch_crc | input | 8*CRC_BYTES | Sector checksum, with fetch_done |
| buf_rd_addr | output | ADDR_W | Sector buffer byte address |
| buf_rd_data | input | 8 | Buffer byte at buf_rd_addr, same cycle |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Host takes the byte |
| tx_data | output | 8 | Outgoing byte |
| tx_last | output | 1 | Final byte of a transaction or checksum |

## Verification
The bench exercises the gates that block progress:
- A data request sent before the status poll, or after the sector is used up, must be refused. A design that skips the poll gate, or that advances its transaction count on a refused request, would stream from the wrong address.
- A checksum request sent too early must be refused. A design that lets it through would move to the next sector early.
- A set-sector command raced against an in-flight fetch must discard the old completion. A design that accepts the stale completion would show 0x81 with the wrong sector's checksum.

Range vectors cover the 2047 limit, reversed spans and a single-sector span. Stalls on the stream show whether held bytes change while `tx_ready` is low.

// File: rtl/rbk_pkg.sv
package rbk_pkg;

  typedef enum logic [2:0] {
    OP_DEVICE = 3'd0,
    OP_SPAN   = 3'd1,
    OP_SEEK   = 3'd2,
    OP_POLL   = 3'd3,
    OP_DATA   = 3'd4,
    OP_SUM    = 3'd5
  } rbk_op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_READY = 3'd2,
    ST_SEND  = 3'd3,
    ST_SUMW  = 3'd4,
    ST_SUMS  = 3'd5,
    ST_ERR   = 3'd6
  } rbk_state_e;

  localparam logic [7:0] RC_OK        = 8'h01;
  localparam logic [7:0] RC_REFUSED   = 8'h02;
  localparam logic [7:0] RC_UNSUP     = 8'h03;
  localparam logic [7:0] RC_SUM_BAD   = 8'h07;
  localparam logic [7:0] RC_BAD_DEV   = 8'h08;
  localparam logic [7:0] RC_NO_DEV    = 8'h23;
  localparam logic [7:0] RC_LOADING   = 8'h80;
  localparam logic [7:0] RC_AVAIL     = 8'h81;
  localparam logic [7:0] RC_BAD_SPAN  = 8'h82;
  localparam logic [7:0] RC_NOTHING   = 8'hFF;

endpackage

// File: rtl/rbk_range_check.sv
module rbk_range_check #(
  parameter int SECT_W     = 16,
  parameter int MAX_SECTOR = 2047
) (
  input  logic [SECT_W-1:0] first_i,
  input  logic [SECT_W-1:0] last_i,
  input  logic [SECT_W-1:0] probe_i,
  input  logic [SECT_W-1:0] win_lo_i,
  input  logic [SECT_W-1:0] win_hi_i,
  output logic              span_ok_o,
  output logic              probe_ok_o
);
  localparam logic [SECT_W-1:0] LIMIT = SECT_W'(MAX_SECTOR);

  assign span_ok_o  = (first_i <= LIMIT) && (last_i <= LIMIT) && (first_i <= last_i);
  assign probe_ok_o = (probe_i >= win_lo_i) && (probe_i <= win_hi_i);
endmodule

// File: rtl/rbk_xfer_counter.sv
module rbk_xfer_counter #(
  parameter int TXN_BYTES = 256,
  parameter int TXNS      = 256,
  parameter int SUM_BYTES = 8,
  localparam int BMAX = (TXN_BYTES > SUM_BYTES) ? TXN_BYTES : SUM_BYTES,
  localparam int BW   = (BMAX > 1) ? $clog2(BMAX) : 1,
  localparam int TW   = (TXNS > 1) ? $clog2(TXNS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          sum_mode_i,
  input  logic          step_i,
  output logic [BW-1:0] byte_o,
  output logic [TW-1:0] txn_o,
  output logic          last_byte_o,
  output logic          txn_done_o,
  output logic          sector_done_o,
  output logic          sum_done_o
);
  localparam logic [BW-1:0] DATA_LAST = BW'(TXN_BYTES - 1);
  localparam logic [BW-1:0] SUM_LAST  = BW'(SUM_BYTES - 1);
  localparam logic [TW-1:0] TXN_LAST  = TW'(TXNS - 1);

  logic [BW-1:0] byte_q;
  logic [TW-1:0] txn_q;

  assign byte_o        = byte_q;
  assign txn_o         = txn_q;
  assign last_byte_o   = sum_mode_i ? (byte_q == SUM_LAST) : (byte_q == DATA_LAST);
  assign txn_done_o    = step_i && !sum_mode_i && (byte_q == DATA_LAST);
  assign sector_done_o = txn_done_o && (txn_q == TXN_LAST);
  assign sum_done_o    = step_i && sum_mode_i && (byte_q == SUM_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      byte_q <= '0;
      txn_q  <= '0;
    end else if (step_i) begin
      byte_q <= last_byte_o ? '0 : byte_q + BW'(1);
      if (txn_done_o) txn_q <= sector_done_o ? '0 : txn_q + TW'(1);
    end
  end

  p_clear_origin_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (byte_q == '0 && txn_q == '0));

  p_txn_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_done_o && !sector_done_o && !clear_i) |=> (txn_q == $past(txn_q) + TW'(1)));

  p_idle_counts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !clear_i) |=> ($stable(txn_q) && $stable(byte_q)));
endmodule

// File: rtl/rbk_fetch_port.sv
module rbk_fetch_port (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic fetch_valid_o,
  input  logic fetch_ready_i,
  input  logic fetch_done_i,
  input  logic fetch_ok_i,
  output logic ok_o,
  output logic bad_o
);
  logic req_q, fly_q, stale_q;
  logic hand, done_live;

  assign fetch_valid_o = req_q && !fly_q;
  assign hand          = fetch_valid_o && fetch_ready_i;
  assign done_live     = fly_q && fetch_done_i;
  assign ok_o          = done_live && !stale_q && !start_i && fetch_ok_i;
  assign bad_o         = done_live && !stale_q && !start_i && !fetch_ok_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      fly_q   <= 1'b0;
      stale_q <= 1'b0;
    end else begin
      if (hand)           fly_q <= 1'b1;
      else if (done_live) fly_q <= 1'b0;
      if (start_i) begin
        req_q   <= 1'b1;
        stale_q <= (fly_q && !fetch_done_i) || hand;
      end else begin
        if (hand)      req_q   <= 1'b0;
        if (done_live) stale_q <= 1'b0;
      end
    end
  end

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid_o && !fetch_ready_i) |=> fetch_valid_o);

  p_flight_ends_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (fly_q && fetch_done_i) |=> !fly_q);

  p_stale_silent_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (stale_q && fetch_done_i) |-> !(ok_o || bad_o));
endmodule

// File: rtl/flash_readback_seq.sv
module flash_readback_seq
  import rbk_pkg::*;
#(
  parameter int SECT_W          = 16,
  parameter int MAX_SECTOR      = 2047,
  parameter int TXN_BYTES       = 256,
  parameter int TXNS_PER_SECTOR = 256,
  parameter int CRC_BYTES       = 8,
  parameter int DEV_COUNT       = 4,
  parameter int DEV_W           = 3,
  localparam int SECT_BYTES = TXN_BYTES * TXNS_PER_SECTOR,
  localparam int ADDR_W     = $clog2(SECT_BYTES),
  localparam int CRC_W      = 8 * CRC_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [SECT_W-1:0] cmd_arg_a,
  input  logic [SECT_W-1:0] cmd_arg_b,
  output logic              rsp_valid,
  output logic [7:0]        rsp_code,
  output logic              fetch_valid,
  input  logic              fetch_ready,
  output logic [SECT_W-1:0] fetch_sector,
  output logic [DEV_W-1:0]  fetch_dev,
  input  logic              fetch_done,
  input  logic              fetch_ok,
  input  logic [CRC_W-1:0]  fetch_crc,
  output logic [ADDR_W-1:0] buf_rd_addr,
  input  logic [7:0]        buf_rd_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last
);
  localparam int BMAX = (TXN_BYTES > CRC_BYTES) ? TXN_BYTES : CRC_BYTES;
  localparam int BW   = (BMAX > 1) ? $clog2(BMAX) : 1;
  localparam int TW   = (TXNS_PER_SECTOR > 1) ? $clog2(TXNS_PER_SECTOR) : 1;

  rbk_state_e        st_q, st_d;
  logic [SECT_W-1:0] cur_q, cur_d, lo_q, lo_d, hi_q, hi_d;
  logic [DEV_W-1:0]  dev_q, dev_d;
  logic              has_dev_q, has_dev_d;
  logic              armed_q, armed_d;
  logic [7:0]        code_q, code_d;
  logic              rsp_q;
  logic [CRC_W-1:0]  sum_q;
  logic              go_fetch, acc, dev_ok;
  logic              span_ok, probe_ok;
  logic              f_ok, f_bad;
  logic              step, last_byte, txn_done, sector_done, sum_done;
  logic [BW-1:0]     byte_idx;
  logic [TW-1:0]     txn_idx;
  logic [CRC_W-1:0]  sum_shift;
  rbk_op_e           op;

  assign op        = rbk_op_e'(cmd_op);
  assign cmd_ready = (st_q != ST_SEND) && (st_q != ST_SUMS);
  assign acc       = cmd_valid && cmd_ready;
  assign dev_ok    = (cmd_arg_a != '0) && (cmd_arg_a <= SECT_W'(DEV_COUNT));
  assign tx_valid  = (st_q == ST_SEND) || (st_q == ST_SUMS);
  assign step      = tx_valid && tx_ready;

  rbk_range_check #(.SECT_W(SECT_W), .MAX_SECTOR(MAX_SECTOR)) u_range (
    .first_i   (cmd_arg_a),
    .last_i    (cmd_arg_b),
    .probe_i   (cmd_arg_a),
    .win_lo_i  (lo_q),
    .win_hi_i  (hi_q),
    .span_ok_o (span_ok),
    .probe_ok_o(probe_ok)
  );

  rbk_xfer_counter #(.TXN_BYTES(TXN_BYTES), .TXNS(TXNS_PER_SECTOR), .SUM_BYTES(CRC_BYTES)) u_count (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear_i      (go_fetch),
    .sum_mode_i   (st_q == ST_SUMS),
    .step_i       (step),
    .byte_o       (byte_idx),
    .txn_o        (txn_idx),
    .last_byte_o  (last_byte),
    .txn_done_o   (txn_done),
    .sector_done_o(sector_done),
    .sum_done_o   (sum_done)
  );

  rbk_fetch_port u_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (go_fetch),
    .fetch_valid_o(fetch_valid),
    .fetch_ready_i(fetch_ready),
    .fetch_done_i (fetch_done),
    .fetch_ok_i   (fetch_ok),
    .ok_o         (f_ok),
    .bad_o        (f_bad)
  );

  assign fetch_sector = cur_q;
  assign fetch_dev    = dev_q;
  assign buf_rd_addr  = ADDR_W'(txn_idx) * ADDR_W'(TXN_BYTES) + ADDR_W'(byte_idx);
  assign sum_shift    = sum_q >> (8 * byte_idx);
  assign tx_data      = (st_q == ST_SUMS) ? sum_shift[7:0] : buf_rd_data;
  assign tx_last      = tx_valid && last_byte;
  assign rsp_valid    = rsp_q;
  assign rsp_code     = code_q;

  always_comb begin
    st_d      = st_q;
    cur_d     = cur_q;
    lo_d      = lo_q;
    hi_d      = hi_q;
    dev_d     = dev_q;
    has_dev_d = has_dev_q;
    armed_d   = armed_q;
    code_d    = code_q;
    go_fetch  = 1'b0;

    unique case (st_q)
      ST_FETCH: begin
        if (f_ok)       st_d = ST_READY;
        else if (f_bad) st_d = ST_ERR;
      end
      ST_SEND: if (txn_done) st_d = sector_done ? ST_SUMW : ST_READY;
      ST_SUMS: begin
        if (sum_done) begin
          if (cur_q == hi_q) st_d = ST_IDLE;
          else begin
            cur_d    = cur_q + SECT_W'(1);
            st_d     = ST_FETCH;
            go_fetch = 1'b1;
            armed_d  = 1'b0;
          end
        end
      end
      default: ;
    endcase

    if (acc) begin
      code_d = RC_REFUSED;
      case (op)
        OP_DEVICE: begin
          if (dev_ok) begin
            dev_d     = cmd_arg_a[DEV_W-1:0];
            has_dev_d = 1'b1;
            code_d    = RC_OK;
          end else code_d = RC_BAD_DEV;
        end
        OP_SPAN: begin
          if (st_q != ST_IDLE && st_q != ST_ERR) code_d = RC_REFUSED;
          else if (!has_dev_q)                  code_d = RC_NO_DEV;
          else if (!span_ok)                    code_d = RC_BAD_SPAN;
          else begin
            lo_d     = cmd_arg_a;
            hi_d     = cmd_arg_b;
            cur_d    = cmd_arg_a;
            st_d     = ST_FETCH;
            go_fetch = 1'b1;
            armed_d  = 1'b0;
            code_d   = RC_OK;
          end
        end
        OP_SEEK: begin
          if (st_q == ST_IDLE) code_d = RC_REFUSED;
          else if (!probe_ok)  code_d = RC_BAD_SPAN;
          else begin
            cur_d    = cmd_arg_a;
            st_d     = ST_FETCH;
            go_fetch = 1'b1;
            armed_d  = 1'b0;
            code_d   = RC_OK;
          end
        end
        OP_POLL: begin
          case (st_q)
            ST_IDLE:  code_d = RC_NOTHING;
            ST_FETCH: code_d = RC_LOADING;
            ST_ERR:   code_d = RC_SUM_BAD;
            ST_READY, ST_SUMW: begin
              code_d  = RC_AVAIL;
              armed_d = 1'b1;
            end
            default:  code_d = RC_REFUSED;
          endcase
        end
        OP_DATA: begin
          if (st_q == ST_READY && armed_q) begin
            st_d   = ST_SEND;
            code_d = RC_OK;
          end
        end
        OP_SUM: begin
          if (st_q == ST_SUMW) begin
            st_d   = ST_SUMS;
            code_d = RC_OK;
          end
        end
        default: code_d = RC_UNSUP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cur_q     <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
      dev_q     <= '0;
      has_dev_q <= 1'b0;
      armed_q   <= 1'b0;
      code_q    <= RC_NOTHING;
      rsp_q     <= 1'b0;
      sum_q     <= '0;
    end else begin
      st_q      <= st_d;
      cur_q     <= cur_d;
      lo_q      <= lo_d;
      hi_q      <= hi_d;
      dev_q     <= dev_d;
      has_dev_q <= has_dev_d;
      armed_q   <= armed_d;
      code_q    <= code_d;
      rsp_q     <= acc;
      if (f_ok) sum_q <= fetch_crc;
    end
  end

  p_cmd_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !cmd_ready);

  p_tx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(buf_rd_addr) && $stable(tx_last)));

  p_rsp_follows_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cmd_valid && cmd_ready));

  p_cur_window_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |-> (cur_q >= lo_q && cur_q <= hi_q));

  p_sector_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> (fetch_sector <= SECT_W'(MAX_SECTOR)));

  p_data_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SEND && $past(st_q) == ST_READY) |-> $past(armed_q));

  p_sum_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SUMS && $past(st_q) != ST_SUMS) |-> ($past(st_q) == ST_SUMW));
endmodule

// File: tb/sim_flash_readback_seq.sv
module sim_flash_readback_seq;
  localparam int TXB   = 4;
  localparam int TXN   = 4;
  localparam int AW    = 4;
  localparam logic [2:0] OP_T = 3'd0, OP_R = 3'd1, OP_S = 3'd2,
                         OP_P = 3'd3, OP_D = 3'd4, OP_C = 3'd5;
  localparam logic [63:0] SUM_BASE = 64'h0123_4567_89AB_CD00;
  localparam int NVEC = 6;
  localparam logic [39:0] SPAN_VEC [NVEC] = '{
    {16'd0,     16'd2048, 8'h82},
    {16'd2048,  16'd2048, 8'h82},
    {16'd5,     16'd4,    8'h82},
    {16'hFFFF,  16'd1,    8'h82},
    {16'd2047,  16'd2047, 8'h01},
    {16'd0,     16'd2047, 8'h01}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [15:0] cmd_arg_a = '0, cmd_arg_b = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_code;
  logic        fetch_valid;
  logic        fetch_ready = 1'b0;
  logic [15:0] fetch_sector;
  logic [2:0]  fetch_dev;
  logic        fetch_done = 1'b0, fetch_ok = 1'b0;
  logic [63:0] fetch_crc = '0;
  logic [AW-1:0] buf_rd_addr;
  logic [7:0]  buf_rd_data;
  logic        tx_valid, tx_ready = 1'b0, tx_last;
  logic [7:0]  tx_data;
  logic [7:0]  sec_tag = '0;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  assign buf_rd_data = ({4'h0, buf_rd_addr} ^ 8'h5A) + sec_tag;

  flash_readback_seq #(.TXN_BYTES(TXB), .TXNS_PER_SECTOR(TXN)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_arg_a(cmd_arg_a), .cmd_arg_b(cmd_arg_b),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .fetch_valid(fetch_valid),
    .fetch_ready(fetch_ready), .fetch_sector(fetch_sector), .fetch_dev(fetch_dev),
    .fetch_done(fetch_done), .fetch_ok(fetch_ok), .fetch_crc(fetch_crc),
    .buf_rd_addr(buf_rd_addr), .buf_rd_data(buf_rd_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last));

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cmd_valid = 1'b0; fetch_ready = 1'b0; fetch_done = 1'b0; tx_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b, output logic [7:0] code);
    int g = 0;
    while (!cmd_ready && g < 50) begin @(negedge clk); g++; end
    cmd_valid = 1'b1; cmd_op = op; cmd_arg_a = a; cmd_arg_b = b;
    @(negedge clk);
    cmd_valid = 1'b0;
    code = rsp_valid ? rsp_code : 8'hEE;
  endtask

  task automatic cmd_expect(input string req, input logic [2:0] op, input logic [15:0] a,
                            input logic [15:0] b, input logic [7:0] exp);
    logic [7:0] c;
    issue(op, a, b, c);
    chk(req, $sformatf("op%0d response", op), {56'd0, c}, {56'd0, exp});
  endtask

  task automatic accept_fetch(input string req, input logic [15:0] sec, input logic [2:0] dev);
    int g = 0;
    while (!fetch_valid && g < 20) begin @(negedge clk); g++; end
    chk(req, "fetch_valid", {63'd0, fetch_valid}, 64'd1);
    chk(req, "fetch_sector", {48'd0, fetch_sector}, {48'd0, sec});
    chk(req, "fetch_dev", {61'd0, fetch_dev}, {61'd0, dev});
    fetch_ready = 1'b1;
    @(negedge clk);
    fetch_ready = 1'b0;
  endtask

  task automatic finish_fetch(input logic [15:0] sec, input logic ok);
    repeat (2) @(negedge clk);
    sec_tag = sec[7:0];
    fetch_crc = SUM_BASE | {48'd0, sec};
    fetch_ok = ok; fetch_done = 1'b1;
    @(negedge clk);
    fetch_done = 1'b0; fetch_ok = 1'b0;
  endtask

  task automatic take_bytes(input string req, input int n, input logic is_sum, input int txn,
                            input logic [15:0] sec, input logic stall);
    int got = 0, guard = 0;
    logic held = 1'b0;
    logic [7:0] prev = '0;
    logic [7:0] exp;
    logic [63:0] sum;
    sum = SUM_BASE | {48'd0, sec};
    chk("R8", "cmd_ready low while streaming", {63'd0, cmd_ready}, 64'd0);
    while (got < n && guard < 200) begin
      if (tx_valid) begin
        if (held) chk("R8", "byte held under stall", {56'd0, tx_data}, {56'd0, prev});
        if (stall && !held) begin
          tx_ready = 1'b0; held = 1'b1; prev = tx_data;
        end else begin
          tx_ready = 1'b1; held = 1'b0;
          exp = is_sum ? sum[8*got +: 8] : (8'((txn * TXB + got)) ^ 8'h5A) + sec[7:0];
          chk(req, $sformatf("byte %0d", got), {56'd0, tx_data}, {56'd0, exp});
          chk(req, "tx_last", {63'd0, tx_last}, {63'd0, (got == n - 1)});
          got++;
        end
      end else tx_ready = 1'b0;
      @(negedge clk);
      guard++;
    end
    tx_ready = 1'b0;
    chk(req, "byte count", 64'(got), 64'(n));
    chk(req, "stream idle after", {63'd0, tx_valid}, 64'd0);
  endtask

  task automatic full_sector(input logic [15:0] sec, input logic stall);
    cmd_expect("R5", OP_P, 0, 0, 8'h81);
    for (int t = 0; t < TXN; t++) begin
      cmd_expect("R7", OP_D, 0, 0, 8'h01);
      take_bytes("R7", TXB, 1'b0, t, sec, stall);
    end
    cmd_expect("R9", OP_D, 0, 0, 8'h02);
    cmd_expect("R9", OP_C, 0, 0, 8'h01);
    take_bytes("R9", 8, 1'b1, 0, sec, stall);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1", "cmd_ready", {63'd0, cmd_ready}, 64'd1);
    chk("R1", "fetch_valid", {63'd0, fetch_valid}, 64'd0);
    chk("R1", "tx_valid", {63'd0, tx_valid}, 64'd0);
    cmd_expect("R1", OP_P, 0, 0, 8'hFF);
    // R3 device select and ordering
    cmd_expect("R3", OP_R, 16'd1, 16'd2, 8'h23);
    cmd_expect("R3", OP_T, 16'd5, 0, 8'h08);
    cmd_expect("R3", OP_T, 16'd0, 0, 8'h08);
    // R13 unsupported ops
    cmd_expect("R13", 3'd6, 0, 0, 8'h03);
    cmd_expect("R13", 3'd7, 0, 0, 8'h03);

    // R2 span vectors
    for (int i = 0; i < NVEC; i++) begin
      do_reset();
      cmd_expect("R3", OP_T, 16'd2, 0, 8'h01);
      cmd_expect("R2", OP_R, SPAN_VEC[i][39:24], SPAN_VEC[i][23:8], SPAN_VEC[i][7:0]);
      if (SPAN_VEC[i][7:0] == 8'h01) cmd_expect("R5", OP_P, 0, 0, 8'h80);
      else cmd_expect("R2", OP_P, 0, 0, 8'hFF);
    end

    // Main flow: sectors 10..11
    do_reset();
    cmd_expect("R3", OP_T, 16'd1, 0, 8'h01);
    cmd_expect("R4", OP_R, 16'd10, 16'd11, 8'h01);
    cmd_expect("R5", OP_P, 0, 0, 8'h80);
    cmd_expect("R6", OP_D, 0, 0, 8'h02);
    accept_fetch("R4", 16'd10, 3'd1);
    finish_fetch(16'd10, 1'b1);
    cmd_expect("R6", OP_D, 0, 0, 8'h02);
    chk("R6", "no stream after refusal", {63'd0, tx_valid}, 64'd0);
    full_sector(16'd10, 1'b1);
    accept_fetch("R10", 16'd11, 3'd1);
    finish_fetch(16'd11, 1'b1);
    cmd_expect("R5", OP_P, 0, 0, 8'h81);
    cmd_expect("R9", OP_C, 0, 0, 8'h02);
    full_sector(16'd11, 1'b0);
    cmd_expect("R10", OP_P, 0, 0, 8'hFF);
    chk("R10", "no fetch after end", {63'd0, fetch_valid}, 64'd0);

    // R11 set-sector restart
    do_reset();
    cmd_expect("R11", OP_S, 16'd5, 0, 8'h02);
    cmd_expect("R3", OP_T, 16'd3, 0, 8'h01);
    cmd_expect("R4", OP_R, 16'd20, 16'd23, 8'h01);
    accept_fetch("R4", 16'd20, 3'd3);
    finish_fetch(16'd20, 1'b1);
    cmd_expect("R5", OP_P, 0, 0, 8'h81);
    cmd_expect("R7", OP_D, 0, 0, 8'h01);
    take_bytes("R7", TXB, 1'b0, 0, 16'd20, 1'b0);
    cmd_expect("R11", OP_S, 16'd22, 0, 8'h01);
    accept_fetch("R11", 16'd22, 3'd3);
    finish_fetch(16'd22, 1'b1);
    cmd_expect("R11", OP_P, 0, 0, 8'h81);
    cmd_expect("R11", OP_D, 0, 0, 8'h01);
    take_bytes("R11", TXB, 1'b0, 0, 16'd22, 1'b1);
    cmd_expect("R11", OP_S, 16'd30, 0, 8'h82);
    cmd_expect("R11", OP_S, 16'd19, 0, 8'h82);

    // R12 set-sector during in-flight fetch, then R5 failure path
    do_reset();
    cmd_expect("R3", OP_T, 16'd4, 0, 8'h01);
    cmd_expect("R4", OP_R, 16'd40, 16'd43, 8'h01);
    accept_fetch("R4", 16'd40, 3'd4);
    cmd_expect("R12", OP_S, 16'd42, 0, 8'h01);
    finish_fetch(16'd40, 1'b1);
    cmd_expect("R12", OP_P, 0, 0, 8'h80);
    accept_fetch("R12", 16'd42, 3'd4);
    finish_fetch(16'd42, 1'b1);
    full_sector(16'd42, 1'b1);
    accept_fetch("R10", 16'd43, 3'd4);
    finish_fetch(16'd43, 1'b0);
    cmd_expect("R5", OP_P, 0, 0, 8'h07);
    cmd_expect("R6", OP_D, 0, 0, 8'h02);
    cmd_expect("R11", OP_S, 16'd43, 0, 8'h01);
    accept_fetch("R11", 16'd43, 3'd4);
    finish_fetch(16'd43, 1'b1);
    cmd_expect("R5", OP_P, 0, 0, 8'h81);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule